// File: doc/BRIEF.md
# Per-pin GPIO controller with interrupts

This block controls a set of general-purpose I/O pins. Each pin has its own 32-bit control word that holds the pin's output value, its drive direction, its interrupt configuration and a sticky interrupt flag. The same word reports the pin's current input level. Software reaches the words through a simple register read/write port. For each group of 32 pins there is one read-only word that collects the interrupt flags of that group. The flags of all pins are also ORed onto one interrupt line.

The pad is modelled as three signals: an input level, an output value and an output enable. The input level passes through a synchronizer before the block uses it. Debounce filtering is done by a separate timer block outside this one. A pin whose debounce select field is non-zero takes its level from that external, already-filtered input instead of the synchronizer. A soft-reset input returns pin output state to idle, except on pins that are marked to persist across it.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: The control word of pin p sits at byte address 0x180 + 4p. Bit 0 of the word drives `pad_out[p]`. Bit 1 drives `pad_oe[p]` (1 = output). A write changes only the addressed pin.
- R2: A control word reads back bits 0..9 exactly as written. Bit 0 returns the written output latch, not the pad level. Bits 10, 11 and 14..31 read 0. Addresses that map to no pin and no summary word read 0.
- R3: Bit 13 of a control word is the pin's input level after a two-flop synchronizer. The new level appears on the second rising clock edge after a pad change, not on the first. This holds even when the pin is driven as an output.
- R4: Trigger code bits 5:3 = 000 latches status on a falling input edge. Code 001 latches status on a rising input edge.
- R5: Trigger code 101 latches status on either input edge.
- R6: Trigger code 010 latches status while the input is low. Code 011 latches status while the input is high. A level trigger sets status again on every cycle the level holds, including right after a clear. Codes 100, 110 and 111 never set status.
- R7: Status is set only when interrupt enable (bit 2) is 1 and input mask (bit 9) is 0. Once set, status stays set until it is cleared.
- R8: Writing 1 to bit 12 of a control word clears that pin's status. Writing 0 to bit 12 leaves status unchanged.
- R9: The summary word of bank n sits at 0x100 + 4n. Its bit p equals the status of pin 32n + p. Bits that have no pin read 0.
- R10: `irq_o` is high exactly when at least one pin has status set.
- R11: A one-cycle `soft_rst` clears the output bit and the direction bit of every pin whose bit 6 (persist) is 0. Pins with bit 6 set keep those bits. All other fields are unchanged on every pin.
- R12: When bits 8:7 are non-zero, the pin's input bit and its triggers use `dbc_level[p]` directly, in place of the synchronized pad. Bits 8:7 are also presented on `dbc_sel[2p+1:2p]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Soft reset of pin output state |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pad_in | input | NUM_PINS | Pad input levels |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |
| dbc_level | input | NUM_PINS | Filtered levels from the external debounce block |
| dbc_sel | output | 2*NUM_PINS | Debounce select field of every pin |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a clear that happens while a trigger condition still holds. The stimulus has to make a level trigger win against a write-1-to-clear on the same edge. It also has to keep a previous configuration from setting status again at the moment a new trigger code is loaded. The bench walks every one of the eight trigger codes on a pin in each bank. The sequence is: disable the pin, clear it, then arm it with the pad low. It then applies a rising level, a clear, a falling level and a clear. After each step it compares the status bit, the bank summary and `irq_o` with a value built from the edge and level rules of each code.

// File: rtl/gpc_pkg.sv
`timescale 1ns/1ps
package gpc_pkg;
   localparam int WORD_W = 32;
   localparam int B_STS  = 12;
   localparam int B_IN   = 13;

   typedef enum logic [2:0] {
      TRIG_FALL = 3'b000,
      TRIG_RISE = 3'b001,
      TRIG_LOW  = 3'b010,
      TRIG_HIGH = 3'b011,
      TRIG_BOTH = 3'b101
   } trig_e;

   // writable fields, packed in the order they sit in bits 9..0
   typedef struct packed {
      logic       msk;
      logic [1:0] dsel;
      logic       tol;
      logic [2:0] typ;
      logic       ien;
      logic       dir;
      logic       out;
   } cfg_t;

   function automatic int bank_count(input int pins);
      return (pins + 31) / 32;
   endfunction
endpackage

// File: rtl/gpc_sync.sv
`timescale 1ns/1ps
module gpc_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      if (WIDTH < 1)  $fatal(1, "gpc_sync: WIDTH must be at least 1");
      if (STAGES < 0) $fatal(1, "gpc_sync: STAGES must not be negative");
   end

   generate
      if (STAGES == 0) begin : g_bypass
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/gpc_trigger.sv
`timescale 1ns/1ps
module gpc_trigger
   import gpc_pkg::*;
(
   input  logic [2:0] typ,
   input  logic       cur,
   input  logic       prev,
   output logic       fire
);
   logic rise, fall;
   assign rise = cur & ~prev;
   assign fall = prev & ~cur;

   always_comb begin
      case (typ)
         TRIG_FALL: fire = fall;
         TRIG_RISE: fire = rise;
         TRIG_BOTH: fire = rise | fall;
         TRIG_LOW:  fire = ~cur;
         TRIG_HIGH: fire = cur;
         default:   fire = 1'b0;
      endcase
   end
endmodule

// File: rtl/gpc_pin.sv
`timescale 1ns/1ps
module gpc_pin
   import gpc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              wr_sel,
   input  cfg_t              wr_cfg,
   input  logic              wr_clr,
   input  logic              sync_lvl,
   input  logic              dbc_lvl,
   output logic [WORD_W-1:0] rd_word,
   output logic              pad_out,
   output logic              pad_oe,
   output logic [1:0]        dsel,
   output logic              sts,
   output logic              tol,
   output logic              arm
);
   cfg_t cfg_q;
   logic sts_q, prev_q, cur, fire, hit;

   assign cur = (cfg_q.dsel != 2'b00) ? dbc_lvl : sync_lvl;

   gpc_trigger u_trig (
      .typ  (cfg_q.typ),
      .cur  (cur),
      .prev (prev_q),
      .fire (fire)
   );

   assign hit = cfg_q.ien & ~cfg_q.msk & fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         sts_q  <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         prev_q <= cur;
         sts_q  <= hit | (sts_q & ~(wr_sel & wr_clr));
         if (wr_sel) begin
            cfg_q.ien  <= wr_cfg.ien;
            cfg_q.typ  <= wr_cfg.typ;
            cfg_q.tol  <= wr_cfg.tol;
            cfg_q.dsel <= wr_cfg.dsel;
            cfg_q.msk  <= wr_cfg.msk;
         end
         if (soft_rst && !cfg_q.tol) begin
            cfg_q.out <= 1'b0;
            cfg_q.dir <= 1'b0;
         end else if (wr_sel) begin
            cfg_q.out <= wr_cfg.out;
            cfg_q.dir <= wr_cfg.dir;
         end
      end
   end

   always_comb begin
      rd_word        = '0;
      rd_word[9:0]   = cfg_q;
      rd_word[B_STS] = sts_q;
      rd_word[B_IN]  = cur;
   end

   assign pad_out = cfg_q.out;
   assign pad_oe  = cfg_q.dir;
   assign dsel    = cfg_q.dsel;
   assign sts     = sts_q;
   assign tol     = cfg_q.tol;
   assign arm     = cfg_q.ien & ~cfg_q.msk;
endmodule

// File: rtl/gpc_summary.sv
`timescale 1ns/1ps
module gpc_summary #(
   parameter int NUM_PINS = 40,
   parameter int NB       = 2
) (
   input  logic [NUM_PINS-1:0] sts,
   output logic [NB*32-1:0]    words,
   output logic                any
);
   initial begin
      if (NB * 32 < NUM_PINS) $fatal(1, "gpc_summary: too few banks for the pin count");
   end

   generate
      for (genvar b = 0; b < NB; b++) begin : g_bank
         for (genvar i = 0; i < 32; i++) begin : g_bit
            if (b * 32 + i < NUM_PINS) begin : g_pin
               assign words[b*32+i] = sts[b*32+i];
            end else begin : g_pad
               assign words[b*32+i] = 1'b0;
            end
         end
      end
   endgenerate

   assign any = |sts;
endmodule

// File: rtl/gpio_pin_ctrl.sv
`timescale 1ns/1ps
module gpio_pin_ctrl
   import gpc_pkg::*;
#(
   parameter int NUM_PINS    = 40,
   parameter int ADDR_W      = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  soft_rst,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic                  reg_wr,
   input  logic [WORD_W-1:0]     reg_wdata,
   output logic [WORD_W-1:0]     reg_rdata,
   input  logic [NUM_PINS-1:0]   pad_in,
   output logic [NUM_PINS-1:0]   pad_out,
   output logic [NUM_PINS-1:0]   pad_oe,
   input  logic [NUM_PINS-1:0]   dbc_level,
   output logic [2*NUM_PINS-1:0] dbc_sel,
   output logic                  irq_o
);
   localparam int NB    = bank_count(NUM_PINS);
   localparam int IDX_W = ADDR_W - 2;
   localparam logic [ADDR_W-1:0] SUM_BASE  = ADDR_W'(256);
   localparam logic [ADDR_W-1:0] CTRL_BASE = ADDR_W'(384);

   initial begin
      if (NUM_PINS < 1)    $fatal(1, "gpio_pin_ctrl: NUM_PINS must be at least 1");
      if (ADDR_W < 9)      $fatal(1, "gpio_pin_ctrl: ADDR_W too small for the register map");
      if (384 + 4 * NUM_PINS > (1 << ADDR_W))
         $fatal(1, "gpio_pin_ctrl: control words exceed the address space");
      if (NB * 4 > 128)    $fatal(1, "gpio_pin_ctrl: summary words overlap control words");
      if (SYNC_STAGES < 2) $fatal(1, "gpio_pin_ctrl: SYNC_STAGES must be at least 2");
   end

   // ---------------- address decode ----------------
   logic              aligned, ctrl_hit, sum_hit;
   logic [ADDR_W-1:0] ctrl_off, sum_off;
   logic [IDX_W-1:0]  ctrl_idx, sum_idx;

   assign aligned  = (reg_addr[1:0] == 2'b00);
   assign ctrl_off = reg_addr - CTRL_BASE;
   assign sum_off  = reg_addr - SUM_BASE;
   assign ctrl_idx = ctrl_off[ADDR_W-1:2];
   assign sum_idx  = sum_off[ADDR_W-1:2];
   assign ctrl_hit = aligned && (reg_addr >= CTRL_BASE) && (ctrl_idx < IDX_W'(NUM_PINS));
   assign sum_hit  = aligned && (reg_addr >= SUM_BASE) && (reg_addr < CTRL_BASE)
                     && (sum_idx < IDX_W'(NB));

   // ---------------- write data split ----------------
   cfg_t wr_cfg;
   logic wr_clr;
   logic unused_wdata;
   assign wr_cfg       = cfg_t'(reg_wdata[9:0]);
   assign wr_clr       = reg_wdata[B_STS];
   assign unused_wdata = ^{reg_wdata[WORD_W-1:B_IN], reg_wdata[11:10]};

   // ---------------- pad synchronizer ----------------
   logic [NUM_PINS-1:0] pad_sync;
   gpc_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pad_sync)
   );

   // ---------------- pin slices ----------------
   logic [WORD_W-1:0]   ctrl_rd [NUM_PINS];
   logic [NUM_PINS-1:0] sts_vec, tol_vec, arm_vec, wr_sel;

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         assign wr_sel[p] = reg_wr && ctrl_hit && (ctrl_idx == IDX_W'(p));
         gpc_pin u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .wr_sel   (wr_sel[p]),
            .wr_cfg   (wr_cfg),
            .wr_clr   (wr_clr),
            .sync_lvl (pad_sync[p]),
            .dbc_lvl  (dbc_level[p]),
            .rd_word  (ctrl_rd[p]),
            .pad_out  (pad_out[p]),
            .pad_oe   (pad_oe[p]),
            .dsel     (dbc_sel[2*p+1:2*p]),
            .sts      (sts_vec[p]),
            .tol      (tol_vec[p]),
            .arm      (arm_vec[p])
         );
      end
   endgenerate

   // ---------------- bank summary and combined interrupt ----------------
   logic [NB*32-1:0] sum_words;
   gpc_summary #(.NUM_PINS(NUM_PINS), .NB(NB)) u_sum (
      .sts   (sts_vec),
      .words (sum_words),
      .any   (irq_o)
   );

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata = '0;
      for (int p = 0; p < NUM_PINS; p++)
         if (ctrl_hit && ctrl_idx == IDX_W'(p)) reg_rdata = ctrl_rd[p];
      for (int b = 0; b < NB; b++)
         if (sum_hit && sum_idx == IDX_W'(b)) reg_rdata = sum_words[b*32 +: 32];
   end
endmodule

// File: rtl/gpc_checker.sv
`timescale 1ns/1ps
module gpc_checker #(
   parameter int NUM_PINS = 40
) (
   input logic                clk,
   input logic                rst_n,
   input logic                soft_rst,
   input logic                reg_wr,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic                irq_o,
   input logic [NUM_PINS-1:0] sts_vec,
   input logic [NUM_PINS-1:0] tol_vec,
   input logic [NUM_PINS-1:0] arm_vec
);
   AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_wr && !soft_rst) |=> $stable(pad_oe)); // R1

   AST_STS_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((sts_vec & ~$past(sts_vec) & ~$past(arm_vec)) == '0)); // R7

   AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> ((~sts_vec & $past(sts_vec)) == '0)); // R8

   AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_vec == '0) |-> !irq_o); // R10

   AST_IRQ_RISE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(arm_vec) != '0)); // R10

   AST_SOFT_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> ((pad_oe & ~$past(tol_vec)) == '0)); // R11
endmodule

bind gpio_pin_ctrl gpc_checker #(.NUM_PINS(NUM_PINS)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .soft_rst (soft_rst),
   .reg_wr   (reg_wr),
   .pad_oe   (pad_oe),
   .irq_o    (irq_o),
   .sts_vec  (sts_vec),
   .tol_vec  (tol_vec),
   .arm_vec  (arm_vec)
);

// File: tb/test_gpio_pin_ctrl.sv
`timescale 1ns/1ps
module test_gpio_pin_ctrl;
   localparam int N  = 40;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n, soft_rst, reg_wr;
   logic [AW-1:0] reg_addr;
   logic [31:0]   reg_wdata, reg_rdata;
   logic [N-1:0]  pad_in, pad_out, pad_oe, dbc_level;
   logic [2*N-1:0] dbc_sel;
   logic          irq_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   gpio_pin_ctrl #(.NUM_PINS(N), .ADDR_W(AW), .SYNC_STAGES(2)) i_gpio_pin_ctrl (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .dbc_level(dbc_level), .dbc_sel(dbc_sel), .irq_o(irq_o)
   );

   localparam logic [31:0] IEN = 32'h4;
   localparam logic [31:0] MSK = 32'h200;
   localparam logic [31:0] CLR = 32'h1000;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] ca(input int p);
      return AW'(384 + 4 * p);
   endfunction

   function automatic logic [AW-1:0] sa(input int b);
      return AW'(256 + 4 * b);
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_reg(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // pin back to idle with its status cleared
   task automatic idle_pin(input int p);
      wr_reg(ca(p), 32'h0);
      wr_reg(ca(p), CLR);
   endtask

   // walk one trigger code through low / rise / clear / fall / clear
   task automatic run_trig(input int p, input int code);
      logic [31:0] d, cfg;
      bit s, rise_t, fall_t, hi_t, lo_t;
      string tag;
      rise_t = (code == 1) || (code == 5);
      fall_t = (code == 0) || (code == 5);
      hi_t   = (code == 3);
      lo_t   = (code == 2);
      case (code)
         0, 1:    tag = "R4";
         5:       tag = "R5";
         default: tag = "R6";
      endcase
      cfg = IEN | (32'(code) << 3);
      pad_in[p] = 1'b0;
      tick(4);
      idle_pin(p);
      wr_reg(ca(p), cfg);
      tick(3);
      s = lo_t;
      rd_reg(ca(p), d);
      chk($sformatf("%s code %0d pin %0d steady low", tag, code, p), 32'(d[12]), 32'(s));
      pad_in[p] = 1'b1;
      tick(4);
      s = s | rise_t | hi_t;
      rd_reg(ca(p), d);
      chk($sformatf("%s code %0d pin %0d after rise", tag, code, p), 32'(d[12]), 32'(s));
      rd_reg(sa(p / 32), d);
      chk($sformatf("R9 summary pin %0d code %0d", p, code), d, 32'(s) << (p % 32));
      chk($sformatf("R10 irq pin %0d code %0d", p, code), 32'(irq_o), 32'(s));
      wr_reg(ca(p), cfg | CLR);
      tick(3);
      s = hi_t;
      rd_reg(ca(p), d);
      chk($sformatf("%s code %0d pin %0d clear while high", tag, code, p), 32'(d[12]), 32'(s));
      pad_in[p] = 1'b0;
      tick(4);
      s = s | fall_t | lo_t;
      rd_reg(ca(p), d);
      chk($sformatf("%s code %0d pin %0d after fall", tag, code, p), 32'(d[12]), 32'(s));
      wr_reg(ca(p), cfg | CLR);
      tick(3);
      s = lo_t;
      rd_reg(ca(p), d);
      chk($sformatf("%s code %0d pin %0d clear while low", tag, code, p), 32'(d[12]), 32'(s));
      idle_pin(p);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired before the sequence ended");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, w;
      rst_n = 1'b0; soft_rst = 1'b0; reg_wr = 1'b0;
      reg_addr = '0; reg_wdata = '0; pad_in = '0; dbc_level = '0;
      tick(3);
      rst_n = 1'b1;
      tick(2);

      // reset state
      chk("R1 reset pad_oe", 32'(pad_oe), 32'h0);
      chk("R1 reset pad_out", 32'(pad_out), 32'h0);
      chk("R10 reset irq", 32'(irq_o), 32'h0);
      rd_reg(ca(0), d);
      chk("R2 reset word pin 0", d, 32'h0);

      // every pin: write with junk in reserved bits, read back, check pads
      for (int p = 0; p < N; p++) begin
         w = 32'hFFFF_CC00 | (32'(p * 37) & 32'h3FB);
         wr_reg(ca(p), w);
         rd_reg(ca(p), d);
         chk($sformatf("R2 readback pin %0d", p), d, w & 32'h3FB);
         chk($sformatf("R1 pad_out pin %0d", p), 32'(pad_out[p]), 32'(w[0]));
         chk($sformatf("R1 pad_oe pin %0d", p), 32'(pad_oe[p]), 32'(w[1]));
         if (p > 0) begin
            rd_reg(ca(p - 1), d);
            chk($sformatf("R1 neighbour of pin %0d", p), d, 32'h0);
         end
         wr_reg(ca(p), 32'h0);
      end
      rd_reg(AW'(0), d);
      chk("R2 unmapped 0x000", d, 32'h0);
      rd_reg(sa(2), d);
      chk("R2 unmapped bank 2", d, 32'h0);
      rd_reg(ca(N), d);
      chk("R2 unmapped past last pin", d, 32'h0);
      rd_reg(ca(3) + AW'(1), d);
      chk("R2 misaligned address", d, 32'h0);

      // input bit lags the pad by the synchronizer, output latch reads back
      wr_reg(ca(5), 32'h3);
      pad_in[5] = 1'b0;
      tick(4);
      rd_reg(ca(5), d);
      chk("R2 out latch vs low pad", d, 32'h3);
      pad_in[5] = 1'b1;
      rd_reg(ca(5), d);
      chk("R3 input after one edge", 32'(d[13]), 32'h0);
      rd_reg(ca(5), d);
      chk("R3 input after two edges", 32'(d[13]), 32'h1);
      pad_in[5] = 1'b0;
      tick(4);
      wr_reg(ca(5), 32'h0);

      // all eight trigger codes in both banks
      for (int c = 0; c < 8; c++) begin
         run_trig(3, c);
         run_trig(35, c);
      end

      // enable and mask gating
      idle_pin(7);
      wr_reg(ca(7), IEN | MSK | 32'h8);
      pad_in[7] = 1'b1; tick(4);
      rd_reg(ca(7), d);
      chk("R7 masked rise", 32'(d[12]), 32'h0);
      chk("R7 masked irq", 32'(irq_o), 32'h0);
      pad_in[7] = 1'b0; tick(4);
      wr_reg(ca(7), 32'h8);
      pad_in[7] = 1'b1; tick(4);
      rd_reg(ca(7), d);
      chk("R7 disabled rise", 32'(d[12]), 32'h0);
      pad_in[7] = 1'b0; tick(4);
      wr_reg(ca(7), IEN | 32'h8);
      pad_in[7] = 1'b1; tick(4);
      rd_reg(ca(7), d);
      chk("R7 armed rise", 32'(d[12]), 32'h1);
      tick(6);
      rd_reg(ca(7), d);
      chk("R7 status sticky", 32'(d[12]), 32'h1);

      // write-1-to-clear
      wr_reg(ca(7), IEN | 32'h8);
      rd_reg(ca(7), d);
      chk("R8 write 0 keeps status", 32'(d[12]), 32'h1);
      wr_reg(ca(7), IEN | 32'h8 | CLR);
      rd_reg(ca(7), d);
      chk("R8 write 1 clears status", 32'(d[12]), 32'h0);
      chk("R10 irq after clear", 32'(irq_o), 32'h0);
      pad_in[7] = 1'b0; tick(4);
      idle_pin(7);

      // bank summaries with edge pins
      foreach (pad_in[i]) pad_in[i] = 1'b0;
      wr_reg(ca(0), IEN | 32'h8);
      wr_reg(ca(31), IEN | 32'h8);
      wr_reg(ca(39), IEN | 32'h8);
      pad_in[0] = 1'b1; pad_in[31] = 1'b1; pad_in[39] = 1'b1;
      tick(4);
      rd_reg(sa(0), d);
      chk("R9 bank 0 summary", d, 32'h8000_0001);
      rd_reg(sa(1), d);
      chk("R9 bank 1 summary", d, 32'h0000_0080);
      chk("R10 irq with three pins", 32'(irq_o), 32'h1);
      wr_reg(ca(0), CLR); wr_reg(ca(31), CLR);
      chk("R10 irq with one pin left", 32'(irq_o), 32'h1);
      wr_reg(ca(39), CLR);
      chk("R10 irq all clear", 32'(irq_o), 32'h0);
      pad_in[0] = 1'b0; pad_in[31] = 1'b0; pad_in[39] = 1'b0;
      tick(4);

      // soft reset with and without persist
      wr_reg(ca(10), 32'h43);
      wr_reg(ca(11), 32'h31B);
      @(negedge clk); soft_rst = 1'b1;
      @(negedge clk); soft_rst = 1'b0;
      chk("R11 persist pin pad_out", 32'(pad_out[10]), 32'h1);
      chk("R11 persist pin pad_oe", 32'(pad_oe[10]), 32'h1);
      chk("R11 plain pin pad_out", 32'(pad_out[11]), 32'h0);
      chk("R11 plain pin pad_oe", 32'(pad_oe[11]), 32'h0);
      rd_reg(ca(10), d);
      chk("R11 persist pin word", d, 32'h43);
      rd_reg(ca(11), d);
      chk("R11 plain pin other fields kept", d, 32'h318);
      wr_reg(ca(10), 32'h0);
      wr_reg(ca(11), 32'h0);

      // external filtered level
      wr_reg(ca(20), 32'h80);
      pad_in[20] = 1'b1; dbc_level[20] = 1'b0;
      tick(4);
      rd_reg(ca(20), d);
      chk("R12 input follows filtered low", 32'(d[13]), 32'h0);
      chk("R12 select on port", 32'(dbc_sel[41:40]), 32'h1);
      dbc_level[20] = 1'b1;
      rd_reg(ca(20), d);
      chk("R12 input follows filtered high", 32'(d[13]), 32'h1);
      dbc_level[20] = 1'b0;
      tick(2);
      wr_reg(ca(20), 32'h80 | CLR);
      wr_reg(ca(20), 32'h80 | IEN | 32'h8);
      dbc_level[20] = 1'b1;
      tick(3);
      rd_reg(ca(20), d);
      chk("R12 rise on filtered level", 32'(d[12]), 32'h1);
      wr_reg(ca(20), 32'h80 | IEN | 32'h8 | CLR);
      pad_in[20] = 1'b0; tick(4);
      pad_in[20] = 1'b1; tick(4);
      rd_reg(ca(20), d);
      chk("R12 raw pad edge ignored", 32'(d[12]), 32'h0);
      idle_pin(20);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule